// File: doc/BRIEF.md
# Six-Channel Attenuation Register Slave

This block is the control front end of a six-channel audio volume controller. It watches a two-wire serial bus (SCL, SDA) with the system clock, recognises START and STOP conditions, and accepts write transfers addressed to it. A transfer carries a device address byte, a register-select byte and then any number of data bytes. The data bytes land in six 8-bit attenuation registers, one per output channel.

The select byte chooses a register slot and whether the slot advances after each data byte. Slots 0 to 5 are the channels. Slots 6 and 7 exist only so that an advancing pointer can pass through them. Slots 8 to 15 are dead. Each channel register is also turned into an attenuation figure in dB and a mute flag, which the analog side of the chip uses.

The slave only writes. It acknowledges a byte by asserting an open-drain enable that pulls SDA low.

Top module: `atten_i2c_slave`

## Requirements
- R1: An address byte equal to {6'b100010, addr_sel, 1'b0} is acknowledged. This is 0x88 with addr_sel low and 0x8A with addr_sel high. Any other address byte, including one with the R/W bit (bit 0) set, gets no acknowledge, and the transfer that follows writes nothing.
- R2: SDA falling while SCL is high is a START. It restarts address matching at any point, including in the middle of a transfer. SDA rising while SCL is high is a STOP, and it returns the slave to idle.
- R3: Bytes are taken MSB first on SCL rising edges. An acknowledged byte has sda_oe high through the whole ninth SCL pulse, and sda_oe changes only while SCL is low.
- R4: In the select byte, bits [3:0] choose the slot (0 to 5 map to channels 1 to 6), bit 4 enables auto-increment, and bits [7:5] are ignored. The select byte is always acknowledged.
- R5: With bit 4 of the select byte clear, every data byte up to STOP is written to the same slot.
- R6: With bit 4 set, the slot advances after each data byte. Only bits [2:0] count, so 7 wraps to 0 and bit 3 is kept. Bytes aimed at slots 6 and 7 are acknowledged and discarded.
- R7: Data bytes aimed at slots 8 to 15 change no register and are not acknowledged. The slave still consumes them and stays in step with the bus.
- R8: The dB output of a channel is coarse*8 + fine. Here coarse is register bits [6:3] and fine is bits [2:0]. Bit 7 does not affect the dB or mute outputs.
- R9: The mute flag of a channel is high exactly when its coarse field is 10 or more, which means a total above 79 dB.
- R10: After reset, all six registers read 0 (0 dB, not muted) and sda_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_sel | input | 1 | Address strap; selects bit 1 of the device address |
| sda_oe | output | 1 | Pull SDA low when high (acknowledge) |
| atten_reg | output | 48 | Raw channel registers, channel k at bits [8k+7:8k] |
| atten_db | output | 42 | Attenuation in dB, channel k at bits [7k+6:7k] |
| mute | output | 6 | Per-channel mute flag, bit k for channel k |

## Verification
Single-slot transfers with several data bytes show that only the last byte survives when the pointer holds. Auto-increment runs that start at slot 5 and at slot 14 show the wrap inside the low three bits: one passes through the discarded slots 6 and 7 back to channel 0, and the other stays in the dead region. Address bytes with the strap flipped, and with the R/W bit set, separate a correct match from a loose one. A repeated START followed by a foreign address shows that matching really restarts. Data bytes chosen around 79 dB, at coarse codes 9, 10 and 15 and with bit 7 set, pin down the mute threshold and show that the top bit is ignored.

// File: rtl/atten_pkg.sv
package atten_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_SUB,
    S_DATA,
    S_SKIP
  } bus_state_t;
endpackage

// File: rtl/atten_line_sync.sv
module atten_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/atten_bus_engine.sv
module atten_bus_engine
  import atten_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          SLOT_W   = 4,
  parameter int          NUM_CH   = 6,
  parameter int          AUTO_BIT = 4,
  parameter logic [5:0]  ADDR_HI  = 6'b100010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BITS = CNT_W'(DATA_W);

  bus_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              in_ack;
  logic [SLOT_W-1:0] ptr;
  logic              auto_inc;
  logic              addr_hit;
  logic              receiving;

  assign addr_hit  = (shreg == {ADDR_HI, addr_sel, 1'b0});
  assign receiving = (state == S_ADDR) || (state == S_SUB) || (state == S_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      in_ack   <= 1'b0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      auto_inc <= 1'b0;
      wr_en    <= 1'b0;
      wr_slot  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state   <= S_ADDR;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state   <= S_IDLE;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (receiving) begin
        if (!in_ack) begin
          if (scl_rise && bit_cnt != BITS) begin
            shreg   <= {shreg[DATA_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == BITS) begin
            bit_cnt <= '0;
            in_ack  <= 1'b1;
            case (state)
              S_ADDR: begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                end else begin
                  state  <= S_SKIP;
                  in_ack <= 1'b0;
                end
              end
              S_SUB: begin
                sda_oe   <= 1'b1;
                ptr      <= shreg[SLOT_W-1:0];
                auto_inc <= shreg[AUTO_BIT];
              end
              default: begin
                sda_oe <= ~ptr[SLOT_W-1];
                if (ptr < SLOT_W'(NUM_CH)) begin
                  wr_en   <= 1'b1;
                  wr_slot <= ptr;
                  wr_data <= shreg;
                end
              end
            endcase
          end
        end else if (scl_fall) begin
          in_ack <= 1'b0;
          sda_oe <= 1'b0;
          case (state)
            S_ADDR: state <= S_SUB;
            S_SUB:  state <= S_DATA;
            default: begin
              if (auto_inc)
                ptr <= {ptr[SLOT_W-1], ptr[SLOT_W-2:0] + 1'b1};
            end
          endcase
        end
      end
    end
  end

  // R3: the acknowledge enable is raised only while SCL is low
  a_r3_oe_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
  // R3: the acknowledge enable is dropped only while SCL is low
  a_r3_oe_fall_scl_low: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_s);
  // R2: a STOP leaves the slave idle and off the bus
  a_r2_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (state == S_IDLE) && !sda_oe);
  // R2: a START always restarts address matching
  a_r2_start_addr: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (state == S_ADDR) && (bit_cnt == '0));
  // R1: an unaddressed slave never drives the line
  a_r1_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == S_SKIP) |-> !sda_oe);
endmodule

// File: rtl/atten_regfile.sv
module atten_regfile #(
  parameter int NUM_CH    = 6,
  parameter int DATA_W    = 8,
  parameter int SLOT_W    = 4,
  parameter int FINE_W    = 3,
  parameter int COARSE_W  = 4,
  parameter int MUTE_CODE = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [SLOT_W-1:0]          wr_slot,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_CH*DATA_W-1:0]   reg_flat,
  output logic [NUM_CH*(FINE_W+COARSE_W)-1:0] db_flat,
  output logic [NUM_CH-1:0]          mute
);
  localparam int DB_W = FINE_W + COARSE_W;

  logic [DATA_W-1:0] regs [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [COARSE_W-1:0] coarse;
    assign coarse = regs[i][FINE_W +: COARSE_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (wr_en && wr_slot == SLOT_W'(i)) begin
        regs[i] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        db_flat[i*DB_W +: DB_W] <= '0;
        mute[i]                 <= 1'b0;
      end else begin
        db_flat[i*DB_W +: DB_W] <= {coarse, {FINE_W{1'b0}}} + DB_W'(regs[i][FINE_W-1:0]);
        mute[i]                 <= (coarse >= COARSE_W'(MUTE_CODE));
      end
    end

    assign reg_flat[i*DATA_W +: DATA_W] = regs[i];

    // R5: a channel register changes only on a write aimed at it
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_slot == SLOT_W'(i)) |=> $stable(regs[i]));
  end

  // R7: the engine never issues a write outside the channel slots
  a_r7_slot_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_slot < SLOT_W'(NUM_CH)));
endmodule

// File: rtl/atten_i2c_slave.sv
module atten_i2c_slave #(
  parameter int NUM_CH      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FINE_W      = 3,
  parameter int COARSE_W    = 4,
  parameter int MUTE_CODE   = 10
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                scl_in,
  input  logic                                sda_in,
  input  logic                                addr_sel,
  output logic                                sda_oe,
  output logic [NUM_CH*DATA_W-1:0]            atten_reg,
  output logic [NUM_CH*(FINE_W+COARSE_W)-1:0] atten_db,
  output logic [NUM_CH-1:0]                   mute
);
  localparam int SLOT_W   = 4;
  localparam int AUTO_BIT = SLOT_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [DATA_W-1:0] wr_data;

  atten_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  atten_bus_engine #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W), .NUM_CH(NUM_CH),
    .AUTO_BIT(AUTO_BIT), .ADDR_HI(6'b100010)
  ) u_engine (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data)
  );

  atten_regfile #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .SLOT_W(SLOT_W),
    .FINE_W(FINE_W), .COARSE_W(COARSE_W), .MUTE_CODE(MUTE_CODE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
    .reg_flat(atten_reg), .db_flat(atten_db), .mute(mute)
  );
endmodule

// File: tb/atten_i2c_slave_test.sv
module atten_i2c_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 16;
  localparam int NCH        = 6;

  typedef struct packed {
    logic [7:0]      addr;
    logic [7:0]      sub;
    logic [2:0]      n;
    logic [3:0][7:0] d;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{8'h88, 8'h00, 3'd1, 32'h0000_0005},  // R4 single write ch0
    '{8'h88, 8'h01, 3'd3, 32'h004F_2010},  // R5 hold pointer, last wins
    '{8'h88, 8'h12, 3'd3, 32'h0050_1808},  // R6 auto from 2
    '{8'h88, 8'h15, 3'd4, 32'h3A66_77CF},  // R6 wrap through 6,7 to 0
    '{8'h88, 8'h09, 3'd1, 32'h0000_0044},  // R7 dead slot
    '{8'h88, 8'h1E, 3'd3, 32'h0056_3412},  // R7 auto stays in dead region
    '{8'h8A, 8'h00, 3'd1, 32'h0000_0099},  // R1 wrong strap
    '{8'h89, 8'h00, 3'd1, 32'h0000_0077},  // R1 read bit set
    '{8'h88, 8'hE3, 3'd1, 32'h0000_007F}   // R4 don't-care bits, R9 coarse 15
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tb_scl = 1'b1;
  logic tb_sda = 1'b1;
  logic strap = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [NCH*8-1:0] atten_reg;
  logic [NCH*7-1:0] atten_db;
  logic [NCH-1:0]   mute;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [7:0] mreg [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = tb_sda & ~sda_oe;

  atten_i2c_slave uut (
    .clk(clk), .rst(rst), .scl_in(tb_scl), .sda_in(sda_bus), .addr_sel(strap),
    .sda_oe(sda_oe), .atten_reg(atten_reg), .atten_db(atten_db), .mute(mute)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    tb_sda = 1'b1; wait_clk(HALF);
    tb_scl = 1'b1; wait_clk(HALF);
    tb_sda = 1'b0; wait_clk(HALF);
    tb_scl = 1'b0; wait_clk(HALF);
  endtask

  task automatic bus_stop;
    tb_sda = 1'b0; wait_clk(HALF);
    tb_scl = 1'b1; wait_clk(HALF);
    tb_sda = 1'b1; wait_clk(HALF);
  endtask

  task automatic bus_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tb_sda = b[i]; wait_clk(HALF);
      tb_scl = 1'b1; wait_clk(HALF);
      tb_scl = 1'b0;
    end
    tb_sda = 1'b1; wait_clk(HALF);
    tb_scl = 1'b1; wait_clk(HALF/2);
    ack = ~sda_bus;
    wait_clk(HALF/2);
    tb_scl = 1'b0;
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk(atten_reg[c*8 +: 8] == mreg[c], {tag, " reg"}, atten_reg[c*8 +: 8], mreg[c]);
      chk(atten_db[c*7 +: 7] == {mreg[c][6:3], 3'b000} + {4'b0, mreg[c][2:0]},
          "R8 db", atten_db[c*7 +: 7], mreg[c][6:0]);
      chk(mute[c] == (mreg[c][6:3] >= 4'd10), "R9 mute", mute[c], mreg[c][6:3] >= 4'd10);
    end
  endtask

  task automatic run_xfer(input logic [7:0] a, input logic [7:0] s, input int n,
                          input logic [3:0][7:0] d, input string tag);
    logic ack;
    logic exp_ack;
    logic [3:0] ptr;
    bus_start;
    bus_byte(a, ack);
    exp_ack = (a == {6'b100010, strap, 1'b0});
    chk(ack == exp_ack, "R1 address ack", ack, exp_ack);
    if (!exp_ack) begin
      bus_byte(s, ack);
      chk(ack == 1'b0, "R1 no ack after miss", ack, 0);
      bus_stop; wait_clk(8);
      check_all(tag);
      return;
    end
    bus_byte(s, ack);
    chk(ack == 1'b1, "R4 select ack", ack, 1);
    ptr = s[3:0];
    for (int k = 0; k < n; k++) begin
      bus_byte(d[k], ack);
      chk(ack == ~ptr[3], "R7 data ack", ack, ~ptr[3]);
      if (ptr < 4'd6) mreg[ptr] = d[k];
      if (s[4]) ptr = {ptr[3], ptr[2:0] + 3'd1};
    end
    bus_stop; wait_clk(8);
    chk(sda_oe == 1'b0, "R2 idle after stop", sda_oe, 0);
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    for (int c = 0; c < NCH; c++) mreg[c] = 8'h00;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    // R10 reset state
    chk(sda_oe == 1'b0, "R10 oe at reset", sda_oe, 0);
    check_all("R10");

    for (int v = 0; v < NVEC; v++)
      run_xfer(VEC[v].addr, VEC[v].sub, int'(VEC[v].n), VEC[v].d, "R5/R6 vector");

    // R8 bit 7 ignored and R9 boundary at 79 dB / 80 dB
    run_xfer(8'h88, 8'h11, 2, 32'h0000_50CF, "R8 boundary");

    // R1 strap high: 0x8A matches, 0x88 does not
    strap = 1'b1;
    run_xfer(8'h8A, 8'h02, 1, 32'h0000_0033, "R1 strap high");
    run_xfer(8'h88, 8'h02, 1, 32'h0000_0044, "R1 strap high miss");
    strap = 1'b0;

    // R2 repeated START restarts matching; foreign address then writes nothing
    bus_start;
    bus_byte(8'h88, ack); chk(ack, "R2 first addr", ack, 1);
    bus_byte(8'h04, ack); chk(ack, "R2 first select", ack, 1);
    bus_start;
    bus_byte(8'h90, ack); chk(!ack, "R2 foreign after restart", ack, 0);
    bus_byte(8'h21, ack); chk(!ack, "R2 skipped data", ack, 0);
    bus_start;
    bus_byte(8'h88, ack); chk(ack, "R2 readdress", ack, 1);
    bus_byte(8'h03, ack); chk(ack, "R2 new select", ack, 1);
    bus_byte(8'h2A, ack); chk(ack, "R2 data", ack, 1);
    mreg[3] = 8'h2A;
    bus_stop; wait_clk(8);
    check_all("R2 restart");

    // R2 STOP mid-transfer: bytes after STOP without START are ignored
    bus_start;
    bus_byte(8'h88, ack);
    bus_byte(8'h00, ack);
    bus_stop;
    tb_scl = 1'b0; wait_clk(HALF);
    bus_byte(8'h65, ack); chk(!ack, "R2 idle ignores bytes", ack, 0);
    tb_scl = 1'b1; wait_clk(HALF);
    bus_stop; wait_clk(8);
    check_all("R2 stop");

    // R3 acknowledge released after ninth clock
    chk(sda_oe == 1'b0, "R3 oe released", sda_oe, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule